// File: doc/BRIEF.md
# Receive Ring Descriptor Writer

This block takes frames arriving one byte per cycle and stores them in a circular region of packet memory. It writes the payload of each frame as little-endian 32-bit words. After the last payload word it writes a single header word in the slot just before the payload. The header holds a valid bit, an error bit, a trailer-present bit and the byte length. Software reads frames from the ring. It returns space by giving back a word count, and it can read the current free-word count at all times.

The engine keeps a ring offset and a free-word count. When a frame has been stored, the offset moves past the header and the payload words, wrapping at the ring size. The count goes down by the same number of words. If a frame will not fit, the engine drops it whole and sets a sticky full flag. A rising edge of the enable input re-arms the ring. A receive interrupt bit is set when a frame is stored and cleared by a pulse from software. Memory writes outside a programmed low/high word-address window are suppressed.

The input stream must leave at least one idle cycle after each frame's last byte.

Top module: `rxr_writer`

## Requirements
- R1: Byte i of a frame is stored in payload word i/4, in bits [8*(i%4)+7 : 8*(i%4)]. Payload word k goes to address base + ((head+1+k) mod size). Unused upper lanes of the last word are zero.
- R2: The header word is written at address base + head, with these bits:
  - bit 31: 1 (valid).
  - bit 30: the error flag from the last byte.
  - bit 29: the trailer-present flag from the last byte.
  - bits 28:12: zero.
  - bits 11:1: bits 11:1 of the length rounded up to even.
  - bit 0: the length is odd.
- R3: The header is written after every payload word of its frame. The next frame's header slot is (head + payload words + 1) mod size.
- R4: The free-word count drops by (payload words + 1) for each stored frame. A return pulse adds its word count. The count is readable on `avail_words` and never grows without a return or a re-arm.
- R5: A frame whose header plus payload exceeds the free-word count is dropped whole:
  - the full flag is set;
  - no header is written;
  - the offset, the free-word count and the interrupt are unchanged.
- R6: While the full flag is set, frames are ignored. The flag stays set while enable is low. It is cleared only by a rising edge of enable, which also sets the offset to 0 and the free-word count to the ring size.
- R7: A frame whose first word is processed while enable is low is ignored entirely.
- R8: The interrupt bit is set when a frame is stored and cleared by `irq_clr`. A set in the same cycle as a clear wins.
- R9: No memory write is issued outside [prot_lo, prot_hi]. A suppressed write still counts as stored, and the offset advances as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; rising edge re-arms the ring |
| cfg_base | input | AW | Ring base word address |
| cfg_size | input | AW | Ring size in words |
| prot_lo | input | AW | Lowest writable word address |
| prot_hi | input | AW | Highest writable word address |
| ret_we | input | 1 | Software returns space this cycle |
| ret_words | input | AW | Number of words returned |
| irq_clr | input | 1 | Clear the receive interrupt |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Last byte of frame |
| s_err | input | 1 | Frame error flag, taken with the last byte |
| s_oob | input | 1 | Trailer-present flag, taken with the last byte |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | AW | Packet memory word address |
| mem_wdata | output | 32 | Packet memory write data |
| avail_words | output | AW | Current free words in the ring |
| full | output | 1 | Ring full flag |
| irq | output | 1 | Receive interrupt bit |

## Verification
The bench sweeps the frame length through every value from 1 to 24 bytes and mixes the error and trailer flags. This separates the odd/even length encoding and every partial-last-word lane count. Space is returned after each frame, so headers and payloads fall across the ring's wrap point at many different offsets. Directed runs then cover the remaining behaviour:
- Filling the ring without returning space separates a whole-frame drop from a partial store.
- Frames sent while full or disabled show that nothing is written.
- A narrowed protection window shows that writes are suppressed while the offset still moves on.
- An interrupt clear placed on the exact cycle of a store shows the set-over-clear priority.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W = 12;

  function automatic logic [31:0] make_hdr(input logic err, input logic oob,
                                           input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] ev;
    ev = len + {{(LEN_W-1){1'b0}}, len[0]};
    return {1'b1, err, oob, 17'd0, ev[LEN_W-1:1], len[0]};
  endfunction
endpackage

// File: rtl/rxr_packer.sv
module rxr_packer
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  input  logic             s_err,
  input  logic             s_oob,
  output logic             w_vld,
  output logic             w_first,
  output logic             w_last,
  output logic [31:0]      w_data,
  output logic [LEN_W-1:0] w_len,
  output logic             w_err,
  output logic             w_oob
);
  logic [23:0]      acc;
  logic [1:0]       lane;
  logic [LEN_W-1:0] len_q;
  logic             first_q;
  logic [31:0]      word_n;

  always_comb word_n = {8'd0, acc} | ({24'd0, s_data} << {lane, 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      w_vld   <= 1'b0;
      w_first <= 1'b0;
      w_last  <= 1'b0;
      w_data  <= '0;
      w_len   <= '0;
      w_err   <= 1'b0;
      w_oob   <= 1'b0;
      acc     <= '0;
      lane    <= '0;
      len_q   <= '0;
      first_q <= 1'b1;
    end else begin
      w_vld <= 1'b0;
      if (s_valid) begin
        if (lane == 2'd3 || s_last) begin
          w_vld   <= 1'b1;
          w_data  <= word_n;
          w_first <= first_q;
          w_last  <= s_last;
          w_len   <= len_q + 1'b1;
          w_err   <= s_err;
          w_oob   <= s_oob;
          acc     <= '0;
          lane    <= '0;
          first_q <= s_last;
        end else begin
          acc  <= word_n[23:0];
          lane <= lane + 1'b1;
        end
        len_q <= s_last ? '0 : len_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxr_ring.sv
module rxr_ring #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [AW-1:0] cfg_size,
  input  logic          commit,
  input  logic [AW-1:0] commit_words,
  input  logic          drop,
  input  logic          ret_we,
  input  logic [AW-1:0] ret_words,
  input  logic          irq_clr,
  output logic [AW-1:0] head,
  output logic [AW-1:0] avail,
  output logic          full,
  output logic          irq
);
  logic          en_q;
  logic          rearm;
  logic [AW:0]   nh;
  logic [AW-1:0] add_w, sub_w;

  always_comb begin
    rearm = rx_en & ~en_q;
    nh    = {1'b0, head} + {1'b0, commit_words};
    if (nh >= {1'b0, cfg_size}) nh = nh - {1'b0, cfg_size};
    add_w = ret_we ? ret_words : '0;
    sub_w = commit ? commit_words : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      head  <= '0;
      avail <= '0;
      full  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      en_q <= rx_en;
      if (rearm) begin
        head  <= '0;
        avail <= cfg_size;
        full  <= 1'b0;
      end else begin
        avail <= avail + add_w - sub_w;
        if (commit) head <= nh[AW-1:0];
        if (drop)   full <= 1'b1;
      end
      if (commit)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_size,
  input  logic [AW-1:0] prot_lo,
  input  logic [AW-1:0] prot_hi,
  input  logic          ret_we,
  input  logic [AW-1:0] ret_words,
  input  logic          irq_clr,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          s_err,
  input  logic          s_oob,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [AW-1:0] avail_words,
  output logic          full,
  output logic          irq
);
  logic             w_vld, w_first, w_last, w_err, w_oob;
  logic [31:0]      w_data;
  logic [LEN_W-1:0] w_len;
  logic [AW-1:0]    head;

  logic             acc_q, drop_q, hdr_pend;
  logic [AW-1:0]    cnt_q, hdr_words;
  logic [31:0]      hdr_word;

  logic             cur_acc, cur_drop, take, fits, do_pay, drop_ev;
  logic [AW-1:0]    cur_cnt, pay_addr, hdr_addr;
  logic [AW:0]      need, off;
  logic             pay_ok, hdr_ok;

  rxr_packer u_pack (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_err(s_err), .s_oob(s_oob), .w_vld(w_vld), .w_first(w_first),
    .w_last(w_last), .w_data(w_data), .w_len(w_len), .w_err(w_err), .w_oob(w_oob)
  );

  rxr_ring #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst), .rx_en(rx_en), .cfg_size(cfg_size),
    .commit(hdr_pend), .commit_words(hdr_words), .drop(drop_ev),
    .ret_we(ret_we), .ret_words(ret_words), .irq_clr(irq_clr),
    .head(head), .avail(avail_words), .full(full), .irq(irq)
  );

  always_comb begin
    cur_acc  = w_first ? (rx_en & ~full) : acc_q;
    cur_cnt  = w_first ? '0 : cnt_q;
    cur_drop = w_first ? 1'b0 : drop_q;
    need     = {1'b0, cur_cnt} + 2'd2;
    fits     = need <= {1'b0, avail_words};
    take     = w_vld & cur_acc & ~cur_drop;
    do_pay   = take & fits;
    drop_ev  = take & ~fits;
    off      = {1'b0, head} + {1'b0, cur_cnt} + 1'b1;
    if (off >= {1'b0, cfg_size}) off = off - {1'b0, cfg_size};
    pay_addr = cfg_base + off[AW-1:0];
    hdr_addr = cfg_base + head;
    pay_ok   = (pay_addr >= prot_lo) && (pay_addr <= prot_hi);
    hdr_ok   = (hdr_addr >= prot_lo) && (hdr_addr <= prot_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      hdr_pend  <= 1'b0;
      hdr_word  <= '0;
      hdr_words <= '0;
      acc_q     <= 1'b0;
      drop_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      mem_we <= 1'b0;
      if (hdr_pend) begin
        mem_we    <= hdr_ok;
        mem_addr  <= hdr_addr;
        mem_wdata <= hdr_word;
        hdr_pend  <= 1'b0;
      end else if (do_pay) begin
        mem_we    <= pay_ok;
        mem_addr  <= pay_addr;
        mem_wdata <= w_data;
      end
      if (do_pay && w_last) begin
        hdr_pend  <= 1'b1;
        hdr_word  <= make_hdr(w_err, w_oob, w_len);
        hdr_words <= cur_cnt + 2'd2;
      end
      if (w_vld) begin
        acc_q  <= cur_acc;
        cnt_q  <= cur_cnt + 1'b1;
        drop_q <= cur_drop | drop_ev;
      end
    end
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_en,
  input logic [AW-1:0] prot_lo,
  input logic [AW-1:0] prot_hi,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          ret_we,
  input logic [AW-1:0] avail_words,
  input logic          irq_clr,
  input logic          full,
  input logic          irq
);
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= prot_lo && mem_addr <= prot_hi)); // R9

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (full && !rx_en) |=> full); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R8

  AST_AVAIL_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (!ret_we && !rx_en) |=> (avail_words <= $past(avail_words))); // R4
endmodule

bind rxr_writer rxr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .prot_lo(prot_lo), .prot_hi(prot_hi),
  .mem_we(mem_we), .mem_addr(mem_addr), .ret_we(ret_we),
  .avail_words(avail_words), .irq_clr(irq_clr), .full(full), .irq(irq)
);

// File: tb/rxr_writer_tb.sv
module rxr_writer_tb;
  localparam int AW   = 6;
  localparam int BASE = 8;
  localparam int SIZE = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_en = 1'b0;
  logic [AW-1:0] cfg_base = AW'(BASE);
  logic [AW-1:0] cfg_size = AW'(SIZE);
  logic [AW-1:0] prot_lo = AW'(BASE);
  logic [AW-1:0] prot_hi = AW'(BASE + SIZE - 1);
  logic          ret_we = 1'b0;
  logic [AW-1:0] ret_words = '0;
  logic          irq_clr = 1'b0;
  logic          s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0, s_oob = 1'b0;
  logic [7:0]    s_data = '0;
  logic          mem_we, full, irq;
  logic [AW-1:0] mem_addr, avail_words;
  logic [31:0]   mem_wdata;

  always #2 clk = ~clk;

  rxr_writer #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .ret_we(ret_we), .ret_words(ret_words),
    .irq_clr(irq_clr), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_err(s_err), .s_oob(s_oob), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .avail_words(avail_words), .full(full), .irq(irq)
  );

  logic [31:0] mem [0:63];
  int          wseq [0:63];
  int          nwr = 0, out_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  int          m_head = 0, m_avail = 0;

  initial for (int a = 0; a < 64; a++) begin mem[a] = 32'hA5A5_0000 | a; wseq[a] = 0; end

  always @(negedge clk) if (mem_we) begin
    nwr++;
    mem[mem_addr] = mem_wdata;
    wseq[mem_addr] = nwr;
    if (mem_addr < prot_lo || mem_addr > prot_hi) out_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic logic [31:0] exp_hdr(input int len, input bit err, input bit oob);
    return 32'h8000_0000 | (32'(err) << 30) | (32'(oob) << 29) |
           (32'(len + 1) & 32'hFFE) | 32'(len & 1);
  endfunction

  function automatic logic [31:0] exp_word(input int len, input int seed, input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = bval(seed, 4 * k + j);
    return w;
  endfunction

  task automatic send(input int len, input bit err, input bit oob, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = bval(seed, i); s_last = (i == len - 1);
      s_err = err; s_oob = oob;
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0; s_oob = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic give_back(input int n);
    @(negedge clk); ret_we = 1'b1; ret_words = AW'(n);
    @(negedge clk); ret_we = 1'b0;
    m_avail += n;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    m_head = 0; m_avail = SIZE;
  endtask

  // Check a stored frame against the model and advance the model.
  task automatic check_frame(input int len, input bit err, input bit oob, input int seed);
    int nw, ha, ok, lastseq;
    nw = (len + 3) / 4;
    ha = BASE + m_head;
    chk(mem[ha] == exp_hdr(len, err, oob), "R2 header", mem[ha], exp_hdr(len, err, oob));
    ok = 1; lastseq = 0;
    for (int k = 0; k < nw; k++) begin
      int pa;
      pa = BASE + ((m_head + 1 + k) % SIZE);
      if (mem[pa] != exp_word(len, seed, k)) ok = 0;
      if (wseq[pa] > lastseq) lastseq = wseq[pa];
    end
    chk(ok == 1, "R1 payload words", 32'(ok), 32'd1);
    chk(wseq[ha] > lastseq, "R3 header after payload", 32'(wseq[ha]), 32'(lastseq));
    m_head = (m_head + nw + 1) % SIZE;
    m_avail -= nw + 1;
    chk(avail_words == AW'(m_avail), "R4 avail after store", 32'(avail_words), 32'(m_avail));
    chk(irq == 1'b1, "R8 irq set on store", 32'(irq), 32'd1);
  endtask

  initial begin
    int snap, snap2, hslot;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_we == 1'b0 && full == 1'b0 && irq == 1'b0, "R6 reset state",
        {29'd0, mem_we, full, irq}, 32'd0);
    chk(avail_words == '0, "R4 reset avail", 32'(avail_words), 32'd0);
    rearm();
    chk(avail_words == AW'(SIZE), "R6 rearm loads size", 32'(avail_words), SIZE);

    // Length sweep with wrap-around (R1 R2 R3 R4 R8)
    for (int len = 1; len <= 24; len++) begin
      bit e, o;
      int nw;
      e = (len % 5 == 0); o = (len % 3 == 0);
      nw = (len + 3) / 4;
      clear_irq();
      chk(irq == 1'b0, "R8 irq cleared", 32'(irq), 32'd0);
      send(len, e, o, len);
      check_frame(len, e, o, len);
      give_back(nw + 1);
      @(negedge clk);
      chk(avail_words == AW'(SIZE), "R4 avail after return", 32'(avail_words), SIZE);
    end

    // Set wins over clear in the same cycle (R8)
    clear_irq();
    @(negedge clk); s_valid = 1'b1; s_data = 8'h3C; s_last = 1'b1;
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b1, "R8 set beats clear", 32'(irq), 32'd1);
    m_head = (m_head + 2) % SIZE; m_avail -= 2;
    give_back(2);

    // Disabled: frame ignored (R7)
    clear_irq();
    @(negedge clk); rx_en = 1'b0;
    snap = nwr;
    send(9, 1'b0, 1'b0, 77);
    chk(nwr == snap, "R7 no writes while disabled", 32'(nwr), 32'(snap));
    chk(irq == 1'b0, "R7 no irq while disabled", 32'(irq), 32'd0);
    chk(avail_words == AW'(SIZE), "R7 avail unchanged", 32'(avail_words), SIZE);
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    m_head = 0; m_avail = SIZE;

    // Fill, then overflow (R5 R6)
    for (int f = 0; f < 6; f++) begin
      send(20, 1'b0, 1'b0, 100 + f);
      check_frame(20, 1'b0, 1'b0, 100 + f);
    end
    clear_irq();
    hslot = BASE + m_head;
    snap = mem[hslot];
    send(20, 1'b0, 1'b0, 200);
    chk(full == 1'b1, "R5 full on overflow", 32'(full), 32'd1);
    chk(avail_words == AW'(m_avail), "R5 avail unchanged on drop", 32'(avail_words), 32'(m_avail));
    chk(mem[hslot] == 32'(snap), "R5 no header on drop", mem[hslot], 32'(snap));
    chk(irq == 1'b0, "R5 no irq on drop", 32'(irq), 32'd0);
    snap2 = nwr;
    send(1, 1'b0, 1'b0, 201);
    chk(nwr == snap2, "R6 frames ignored while full", 32'(nwr), 32'(snap2));
    chk(avail_words == AW'(m_avail), "R6 avail frozen while full", 32'(avail_words), 32'(m_avail));
    give_back(6);
    @(negedge clk);
    chk(full == 1'b1, "R6 return keeps full", 32'(full), 32'd1);
    chk(avail_words == AW'(m_avail), "R4 return while full", 32'(avail_words), 32'(m_avail));
    rearm();
    chk(full == 1'b0, "R6 rearm clears full", 32'(full), 32'd0);
    chk(avail_words == AW'(SIZE), "R6 rearm reloads avail", 32'(avail_words), SIZE);
    send(1, 1'b1, 1'b0, 202);
    check_frame(1, 1'b1, 1'b0, 202);
    chk(m_head == 2, "R6 head restarted at zero", 32'(m_head), 32'd2);

    // Protection window (R9)
    @(negedge clk); prot_hi = AW'(BASE + 3);
    snap = mem[BASE + 4];
    send(24, 1'b0, 1'b1, 300);
    chk(mem[BASE + 2] == exp_hdr(24, 1'b0, 1'b1), "R9 in-window header", mem[BASE + 2], exp_hdr(24, 1'b0, 1'b1));
    chk(mem[BASE + 3] == exp_word(24, 300, 0), "R9 in-window payload", mem[BASE + 3], exp_word(24, 300, 0));
    chk(mem[BASE + 4] == 32'(snap), "R9 out-of-window payload suppressed", mem[BASE + 4], 32'(snap));
    m_head = 9; m_avail -= 7;
    chk(avail_words == AW'(m_avail), "R9 offset still advances", 32'(avail_words), 32'(m_avail));
    snap = mem[BASE + 9];
    send(4, 1'b0, 1'b0, 301);
    chk(mem[BASE + 9] == 32'(snap), "R9 out-of-window header suppressed", mem[BASE + 9], 32'(snap));
    m_avail -= 2;
    chk(avail_words == AW'(m_avail), "R9 suppressed frame counted", 32'(avail_words), 32'(m_avail));
    chk(out_cnt == 0, "R9 no write outside window", 32'(out_cnt), 32'd0);
    @(negedge clk); prot_hi = AW'(BASE + SIZE - 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule